// File: doc/BRIEF.md
# Programmable-Framing Asynchronous Character Receiver

This block turns an asynchronous serial line into characters. A sampling clock enable runs at one, sixteen or sixty-four times the bit rate. The block watches the line for a falling edge and, at the faster rates, confirms it at mid-bit. It then samples each data bit once at its centre, least significant bit first. Depending on the framing setting, it also samples a parity bit and the stop bit. The character width runs from five to eight bits.

Each finished character goes into a single holding register, and a ready flag is raised. Parity, framing and overrun problems are recorded in three flags. The flags stay set until the error-clear pulse removes them. A data-taken pulse from the consumer drops the ready flag. Reception runs only while the receive-enable input is high.

Framing inputs (`rate_sel`, `len_sel`, `par_en`, `par_even`) are taken live and must be held steady while a character is in flight. `rxd` is assumed to be already synchronous to `clk`.

Top module: `prog_async_rx`

## Requirements
- R1: `len_sel` selects the character width (00→5, 01→6, 10→7, 11→8 bits). The first data bit received lands in bit 0 of `rx_data`, and bits above the selected width read as 0.
- R2: With `par_en`=1, one parity bit follows the data. `par_even`=1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `err_parity`.
- R3: A 0 sampled at the stop position sets `err_frame`. The character is still stored, and `rx_ready` is still raised.
- R4: `rx_ready` rises in the clock after the stop-bit sample. A `rd_take` pulse drops it.
- R5: Nothing is received while `rx_enable` is 0. Dropping `rx_enable` mid-character abandons that character.
- R6: `err_parity`, `err_overrun` and `err_frame` stay set until an `err_clear` pulse. A flag set by a character completing in the same cycle as `err_clear` stays set.
- R7: `err_overrun` is set when a character completes while `rx_ready` is 1 and `rd_take` is 0 in that cycle. The new character overwrites `rx_data`. With `rd_take` high in that same cycle, no overrun is recorded and `rx_ready` stays 1.
- R8: At ×16 and ×64, a low that is no longer low at half a bit time after the edge is treated as a glitch, and no character results.
- R9: `rate_sel` encodes the sampling factor: 00→×1, 01→×16, 1x→×64. The start is the first enabled tick seeing 0 after a 1. Each later bit is sampled once, at factor/2 ticks plus a whole number of bit times after it (at ×1, one tick per bit).
- R10: After reset, `rx_data` is 0, and `rx_ready` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sampling tick at factor × bit rate |
| rxd | input | 1 | Serial line, idle high |
| rate_sel | input | 2 | Sampling factor select |
| len_sel | input | 2 | Character width select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even (1) or odd (0) parity |
| rx_enable | input | 1 | Receiver enable |
| rd_take | input | 1 | Consumer took the character |
| err_clear | input | 1 | Clear all error flags |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |

## Verification
Two collisions can fall on the same clock:
- **Completion and take.** A character can complete in the same cycle that the consumer pulses `rd_take`. The bench raises `rd_take` exactly on the tick that samples the stop bit, so the two coincide. The expected result is no overrun and a still-raised ready flag holding the new character.
- **Completion and clear.** A character carrying an error can complete in the same cycle as `err_clear`. This is provoked the same way, with the clear pulse on the stop-bit tick. The expected result is that the new error flag survives.

A behavioural model, driven by tick arithmetic rather than a state machine, predicts every output on every clock. A wrong priority at either collision therefore shows up in the same cycle.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_PAR,
    RXS_STOP
  } rx_phase_e;

  // Maps the rate select code to ticks per bit.
  function automatic int unsigned rate_divisor(input logic [1:0] sel,
                                               input int unsigned mid_div,
                                               input int unsigned max_div);
    case (sel)
      2'b00:   return 1;
      2'b01:   return mid_div;
      default: return max_div;
    endcase
  endfunction

endpackage

// File: rtl/rx_frame_timer.sv
module rx_frame_timer
  import rx_frame_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MID_DIV = 16,
  parameter int MAX_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       enable,
  input  logic [1:0] rate,
  input  logic [1:0] len,
  input  logic       par_en,
  output logic       start_evt,
  output logic       data_evt,
  output logic       par_evt,
  output logic       stop_evt,
  output logic       busy
);
  localparam int CNT_W = $clog2(MAX_DIV);
  localparam int BIT_W = $clog2(DATA_W + 1);

  rx_phase_e        phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_m1;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W:0]   div_w;
  logic [BIT_W-1:0] bits_left;
  logic [BIT_W-1:0] char_len;
  logic             line_prev;
  logic             fast;
  logic             at_period;
  logic             at_half;
  logic             live;

  always_comb begin
    div_w    = (CNT_W + 1)'(rate_divisor(rate, MID_DIV, MAX_DIV));
    per_m1   = CNT_W'(div_w - (CNT_W + 1)'(1));
    half_m1  = CNT_W'((div_w >> 1) - (CNT_W + 1)'(1));
    fast     = (div_w == (CNT_W + 1)'(1));
    char_len = BIT_W'(DATA_W - 3) + BIT_W'(len);
  end

  assign live      = tick && enable;
  assign at_period = (cnt == per_m1);
  assign at_half   = (cnt == half_m1);
  assign start_evt = live && (phase == RXS_IDLE) && !rxd && line_prev;
  assign data_evt  = live && (phase == RXS_DATA) && at_period;
  assign par_evt   = live && (phase == RXS_PAR)  && at_period;
  assign stop_evt  = live && (phase == RXS_STOP) && at_period;
  assign busy      = (phase != RXS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= RXS_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      line_prev <= 1'b1;
    end else begin
      if (tick) line_prev <= rxd;
      if (!enable) begin
        phase <= RXS_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (phase)
          RXS_IDLE: begin
            if (start_evt) begin
              phase     <= fast ? RXS_DATA : RXS_START;
              cnt       <= '0;
              bits_left <= char_len;
            end
          end
          RXS_START: begin
            if (at_half) begin
              cnt   <= '0;
              phase <= rxd ? RXS_IDLE : RXS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_DATA: begin
            if (at_period) begin
              cnt       <= '0;
              bits_left <= bits_left - 1'b1;
              if (bits_left == BIT_W'(1)) phase <= par_en ? RXS_PAR : RXS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_PAR: begin
            if (at_period) begin
              cnt   <= '0;
              phase <= RXS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_STOP: begin
            if (at_period) begin
              cnt   <= '0;
              phase <= RXS_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= RXS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              data_evt,
  input  logic              par_evt,
  input  logic              rxd,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] char_out,
  output logic              par_bad
);
  logic [DATA_W-1:0] shreg;
  logic              par_bit;

  // Bits enter at the top and move down, so the first bit ends lowest.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      par_bit <= 1'b0;
    end else begin
      if (start_evt)     shreg <= '0;
      else if (data_evt) shreg <= {rxd, shreg[DATA_W-1:1]};
      if (par_evt) par_bit <= rxd;
    end
  end

  // Short characters sit high in the register; align them to bit 0.
  assign char_out = shreg >> (2'd3 - len);
  assign par_bad  = par_en && (((^char_out) ^ par_bit) == par_even);
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] char_in,
  input  logic              par_bad,
  input  logic              stop_bit,
  input  logic              rd_take,
  input  logic              err_clear,
  output logic [DATA_W-1:0] data_out,
  output logic              ready,
  output logic              pe,
  output logic              oe,
  output logic              fe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      ready    <= 1'b0;
      pe       <= 1'b0;
      oe       <= 1'b0;
      fe       <= 1'b0;
    end else begin
      pe <= (pe && !err_clear) || (done && par_bad);
      fe <= (fe && !err_clear) || (done && !stop_bit);
      oe <= (oe && !err_clear) || (done && ready && !rd_take);
      if (done) begin
        data_out <= char_in;
        ready    <= 1'b1;
      end else if (rd_take) begin
        ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_async_rx.sv
module prog_async_rx #(
  parameter int DATA_W  = 8,
  parameter int MID_DIV = 16,
  parameter int MAX_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic              rxd,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              rx_enable,
  input  logic              rd_take,
  input  logic              err_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_frame
);
  logic              start_evt;
  logic              data_evt;
  logic              par_evt;
  logic              frame_done;
  logic              rx_busy;
  logic [DATA_W-1:0] char_w;
  logic              par_bad;

  rx_frame_timer #(
    .DATA_W (DATA_W),
    .MID_DIV(MID_DIV),
    .MAX_DIV(MAX_DIV)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (sample_en),
    .rxd      (rxd),
    .enable   (rx_enable),
    .rate     (rate_sel),
    .len      (len_sel),
    .par_en   (par_en),
    .start_evt(start_evt),
    .data_evt (data_evt),
    .par_evt  (par_evt),
    .stop_evt (frame_done),
    .busy     (rx_busy)
  );

  rx_char_assembler #(
    .DATA_W(DATA_W)
  ) i_asm (
    .clk      (clk),
    .rst      (rst),
    .start_evt(start_evt),
    .data_evt (data_evt),
    .par_evt  (par_evt),
    .rxd      (rxd),
    .len      (len_sel),
    .par_en   (par_en),
    .par_even (par_even),
    .char_out (char_w),
    .par_bad  (par_bad)
  );

  rx_hold_reg #(
    .DATA_W(DATA_W)
  ) i_hold (
    .clk      (clk),
    .rst      (rst),
    .done     (frame_done),
    .char_in  (char_w),
    .par_bad  (par_bad),
    .stop_bit (rxd),
    .rd_take  (rd_take),
    .err_clear(err_clear),
    .data_out (rx_data),
    .ready    (rx_ready),
    .pe       (err_parity),
    .oe       (err_overrun),
    .fe       (err_frame)
  );
endmodule

// File: rtl/prog_async_rx_chk.sv
module prog_async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rxd,
  input logic [1:0]        len_sel,
  input logic              rx_enable,
  input logic              rd_take,
  input logic              err_clear,
  input logic              frame_done,
  input logic              rx_busy,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              err_parity,
  input logic              err_overrun,
  input logic              err_frame
);
  assert_ready_after_char_R4: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rx_ready);

  assert_short_char_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_done && len_sel == 2'b00) |=> (rx_data[DATA_W-1 -: 3] == 3'b000));

  assert_stop_low_sets_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !rxd) |=> err_frame);

  assert_parity_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (err_parity && !err_clear) |=> err_parity);

  assert_frame_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !err_clear) |=> err_frame);

  assert_clear_empties_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (err_clear && !frame_done) |=> (!err_parity && !err_overrun && !err_frame));

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_ready && !rd_take) |=> err_overrun);

  assert_no_overrun_on_take_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rd_take && !err_overrun) |=> (!err_overrun && rx_ready));

  assert_idle_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> !rx_busy);
endmodule

bind prog_async_rx prog_async_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .rxd        (rxd),
  .len_sel    (len_sel),
  .rx_enable  (rx_enable),
  .rd_take    (rd_take),
  .err_clear  (err_clear),
  .frame_done (frame_done),
  .rx_busy    (rx_busy),
  .rx_data    (rx_data),
  .rx_ready   (rx_ready),
  .err_parity (err_parity),
  .err_overrun(err_overrun),
  .err_frame  (err_frame)
);

// File: tb/test_prog_async_rx.sv
module test_prog_async_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       sample_en, rxd, par_en, par_even, rx_enable, rd_take, err_clear;
  logic [1:0] rate_sel, len_sel;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_overrun, err_frame;

  int n_checks = 0;
  int n_err    = 0;
  bit started  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prog_async_rx i_prog_async_rx (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rxd(rxd),
    .rate_sel(rate_sel), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .rx_enable(rx_enable), .rd_take(rd_take), .err_clear(err_clear),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_frame(err_frame)
  );

  // Behavioural reference: bit positions come from tick arithmetic.
  int         m_tick, m_t0, m_fac, m_len, m_first;
  bit         m_busy, m_prev, m_pen, m_even, m_parb;
  logic [7:0] m_acc, m_data;
  bit         m_ready, m_pe, m_oe, m_fe;

  always @(posedge clk) begin
    bit done, stopv, bad;
    done = 0; stopv = 1; bad = 0;
    if (rst) begin
      m_tick = 0; m_busy = 0; m_prev = 1; m_data = 0;
      m_ready = 0; m_pe = 0; m_oe = 0; m_fe = 0;
    end else begin
      if (!rx_enable) m_busy = 0;
      if (sample_en) begin
        m_tick++;
        if (rx_enable) begin
          if (!m_busy) begin
            if (!rxd && m_prev) begin
              m_busy = 1; m_t0 = m_tick;
              m_fac = (rate_sel == 2'b00) ? 1 : (rate_sel == 2'b01) ? 16 : 64;
              m_len = 5 + int'(len_sel);
              m_pen = par_en; m_even = par_even; m_acc = 0;
              m_first = (m_fac == 1) ? 0 : m_fac / 2;
            end
          end else begin
            int rel, idx;
            rel = m_tick - m_t0;
            if (m_fac > 1 && rel == m_first) begin
              if (rxd) m_busy = 0;
            end else if (rel > m_first && (rel - m_first) % m_fac == 0) begin
              idx = (rel - m_first) / m_fac - 1;
              if (idx < m_len) m_acc[idx] = rxd;
              else if (m_pen && idx == m_len) m_parb = rxd;
              else begin done = 1; stopv = rxd; m_busy = 0; end
            end
          end
        end
        m_prev = rxd;
      end
      if (done) bad = m_pen && (((^m_acc) ^ m_parb) != !m_even);
      m_oe = (m_oe && !err_clear) || (done && m_ready && !rd_take);
      m_pe = (m_pe && !err_clear) || bad;
      m_fe = (m_fe && !err_clear) || (done && !stopv);
      if (done) begin m_data = m_acc; m_ready = 1; end
      else if (rd_take) m_ready = 0;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      n_checks++;
      if (rx_data !== m_data) begin n_err++;
        $display("FAIL R1 model rx_data actual %0h expected %0h", rx_data, m_data); end
      else if (rx_ready !== m_ready) begin n_err++;
        $display("FAIL R4 model rx_ready actual %0b expected %0b", rx_ready, m_ready); end
      else if (err_parity !== m_pe) begin n_err++;
        $display("FAIL R2 model err_parity actual %0b expected %0b", err_parity, m_pe); end
      else if (err_overrun !== m_oe) begin n_err++;
        $display("FAIL R7 model err_overrun actual %0b expected %0b", err_overrun, m_oe); end
      else if (err_frame !== m_fe) begin n_err++;
        $display("FAIL R3 model err_frame actual %0b expected %0b", err_frame, m_fe); end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_tick(input bit take, input bit clr);
    repeat (TICK_DIV - 1) @(negedge clk);
    sample_en = 1; rd_take = take; err_clear = clr;
    @(negedge clk);
    sample_en = 0; rd_take = 0; err_clear = 0;
  endtask

  // hook: 1 pulses rd_take, 2 pulses err_clear on the stop-bit sample tick.
  task automatic send_frame(input int fac, input logic [7:0] val, input int len,
                            input bit pen, input bit pbit, input bit stopb, input int hook);
    int off;
    off = (fac == 1) ? 0 : fac / 2;
    rxd = 0; repeat (fac) do_tick(0, 0);
    for (int i = 0; i < len; i++) begin rxd = val[i]; repeat (fac) do_tick(0, 0); end
    if (pen) begin rxd = pbit; repeat (fac) do_tick(0, 0); end
    rxd = stopb;
    for (int k = 0; k < fac; k++) do_tick(hook == 1 && k == off, hook == 2 && k == off);
    rxd = 1; repeat (2) do_tick(0, 0);
  endtask

  // x16, 8 bits, no parity: each data bit is correct only near its centre.
  task automatic send_pinched(input logic [7:0] val);
    rxd = 0; repeat (16) do_tick(0, 0);
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 16; k++) begin
        rxd = (k >= 7 && k <= 9) ? val[i] : ~val[i];
        do_tick(0, 0);
      end
    rxd = 1; repeat (18) do_tick(0, 0);
  endtask

  task automatic pulse_take_clear();
    @(negedge clk); rd_take = 1; err_clear = 1;
    @(negedge clk); rd_take = 0; err_clear = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1; sample_en = 0; rxd = 1; rate_sel = 2'b01; len_sel = 2'b11;
    par_en = 0; par_even = 0; rx_enable = 0; rd_take = 0; err_clear = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    started = 1;
    check("R10", "reset rx_data", rx_data, 0);
    check("R10", "reset flags", {rx_ready, err_parity, err_overrun, err_frame}, 0);

    rx_enable = 1;
    repeat (4) do_tick(0, 0);
    send_frame(16, 8'hA5, 8, 0, 0, 1, 0);
    check("R1", "x16 8-bit data", rx_data, 8'hA5);
    check("R4", "ready after char", rx_ready, 1);
    pulse_take_clear();
    check("R4", "ready dropped by take", rx_ready, 0);

    rate_sel = 2'b00; len_sel = 2'b00;
    send_frame(1, 8'hF3, 5, 0, 0, 1, 0);
    check("R1", "x1 5-bit upper zero", rx_data, 8'h13);
    pulse_take_clear();

    rate_sel = 2'b10; len_sel = 2'b10; par_en = 1; par_even = 1;
    send_frame(64, 8'h55, 7, 1, 0, 1, 0);
    check("R2", "good even parity", err_parity, 0);
    check("R9", "x64 7-bit data", rx_data, 8'h55);
    pulse_take_clear();
    send_frame(64, 8'h55, 7, 1, 1, 1, 0);
    check("R2", "bad even parity", err_parity, 1);

    rate_sel = 2'b01; len_sel = 2'b11; par_even = 0;
    send_frame(16, 8'h01, 8, 1, 0, 1, 0);
    check("R6", "parity flag sticky after good char", err_parity, 1);
    check("R7", "overrun from untaken char", err_overrun, 1);
    pulse_take_clear();
    check("R6", "clear empties flags", {err_parity, err_overrun, err_frame}, 0);
    send_frame(16, 8'h01, 8, 1, 1, 1, 0);
    check("R2", "bad odd parity", err_parity, 1);
    pulse_take_clear();
    par_en = 0;

    send_frame(16, 8'h7E, 8, 0, 0, 0, 0);
    check("R3", "stop low sets frame", err_frame, 1);
    check("R3", "char still stored", {rx_ready, rx_data}, {1'b1, 8'h7E});
    pulse_take_clear();

    send_frame(16, 8'h11, 8, 0, 0, 1, 0);
    send_frame(16, 8'h22, 8, 0, 0, 1, 0);
    check("R7", "overrun set", err_overrun, 1);
    check("R7", "overrun overwrites", rx_data, 8'h22);
    pulse_take_clear();

    send_frame(16, 8'h33, 8, 0, 0, 1, 0);
    send_frame(16, 8'h44, 8, 0, 0, 1, 1);
    check("R7", "take at completion no overrun", err_overrun, 0);
    check("R7", "take at completion keeps ready", {rx_ready, rx_data}, {1'b1, 8'h44});
    pulse_take_clear();

    send_frame(16, 8'h66, 8, 0, 0, 0, 2);
    check("R6", "new error beats clear", err_frame, 1);
    pulse_take_clear();

    rxd = 0; repeat (4) do_tick(0, 0);
    rxd = 1; repeat (48) do_tick(0, 0);
    check("R8", "x16 glitch ignored", rx_ready, 0);
    rate_sel = 2'b10;
    rxd = 0; repeat (20) do_tick(0, 0);
    rxd = 1; repeat (160) do_tick(0, 0);
    check("R8", "x64 glitch ignored", rx_ready, 0);
    rate_sel = 2'b01;
    send_frame(16, 8'h5A, 8, 0, 0, 1, 0);
    check("R8", "char after glitch", rx_data, 8'h5A);
    pulse_take_clear();

    send_pinched(8'hC3);
    check("R9", "mid-bit sampling", {rx_ready, rx_data}, {1'b1, 8'hC3});
    pulse_take_clear();

    rx_enable = 0;
    send_frame(16, 8'h3C, 8, 0, 0, 1, 0);
    check("R5", "disabled receives nothing", rx_ready, 0);
    rx_enable = 1;
    rxd = 0; repeat (16) do_tick(0, 0);
    rxd = 1; repeat (64) do_tick(0, 0);
    @(negedge clk); rx_enable = 0;
    @(negedge clk); rx_enable = 1;
    repeat (200) do_tick(0, 0);
    check("R5", "abandoned char", {rx_ready, err_parity, err_overrun, err_frame}, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule